// File: doc/BRIEF.md
# Ring Oscillator Entropy Collector

This block turns the phase jitter of a bank of free-running oscillators into 32-bit words of raw entropy. Each oscillator is the carry of a one-bit full adder whose inverted carry-out is wired back to its own carry-in. The two adder operands come from module inputs, so the loop cannot be folded into a constant. An operand pair whose bits differ, for example `op_a` all ones and `op_b` all zeros, makes every carry toggle continuously. A programmable prescaler derives a slow one-cycle sample strobe from the system clock. On each strobe the synchronized oscillator outputs are XOR-reduced to a single bit, and that bit is shifted into a word register.

After 32 samples the word is placed in an output register and offered to a consumer with a valid/acknowledge handshake. Collection continues in the background while a word waits. A word that completes while the previous one is still unacknowledged is discarded. With `EXT_OSC` set, the feedback loop is opened and each carry-in is driven from `osc_ext`. This gives simulation a deterministic oscillator bank. Because the 32 inversions cancel in the XOR, each sampled bit then equals the parity of `osc_ext`. Statistical health testing and conditioning are done elsewhere.

Top module: `roent_collector`

## Requirements
- R1: While `rst_n` is low and after its release, `word_valid` is 0 and `word_out` is 0 until a word completes.
- R2: With `enable` high, samples are taken at the (`div_limit`+1)-th rising edge at which `enable` is high, and every `div_limit`+1 edges after that. The prescaler restarts from zero whenever `enable` is low.
- R3: The bit taken at a sample edge is the XOR of all 32 oscillator outputs as they stood two rising edges earlier. In `EXT_OSC` mode with `op_a`=all ones and `op_b`=0, that bit is the parity of `osc_ext`.
- R4: Sampled bits enter the word at bit 0 and move toward bit 31, so the first sample of a word ends up in bit 31 and the 32nd in bit 0.
- R5: At the edge of a word's 32nd sample, if `word_valid` was low, `word_out` takes the completed word and `word_valid` rises at that same edge.
- R6: Once high, `word_valid` stays high and `word_out` stays unchanged until an edge samples `word_ack` high. That edge clears `word_valid`.
- R7: Sampling continues while a word is pending. A word completed while `word_valid` is high is discarded, and `word_out` keeps the pending word.
- R8: While `enable` is low, `word_valid`, the sample count and the prescaler are cleared. After `enable` returns, a complete fresh word of 32 samples is assembled before the next `word_valid`.
- R9: `word_ack` sampled while `word_valid` is low has no effect on the sample count or on the word being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the oscillators and collection; low clears collection state |
| op_a | input | NOSC | First adder operand per oscillator |
| op_b | input | NOSC | Second adder operand per oscillator |
| osc_ext | input | NOSC | Carry-in drive per oscillator when `EXT_OSC` is set |
| div_limit | input | DIV_W | Prescaler terminal count; sample period is `div_limit`+1 cycles |
| word_out | output | WORD_W | Completed entropy word |
| word_valid | output | 1 | A word is waiting in `word_out` |
| word_ack | input | 1 | Consumer acknowledge, sampled on the rising edge |

## Verification
A sample bit reflects `osc_ext` as it stood two rising edges before the strobe edge. The bench therefore changes the oscillator pattern on the falling edge right after each strobe and keeps `div_limit` at 2 or more, so every pattern is settled through the synchronizer in time. The first strobe falls at the (`div_limit`+1)-th enabled edge and the rest follow every `div_limit`+1 edges. `word_valid` is due at the 32nd strobe edge itself. The driver computes that edge on its own and records it with the expected word. The monitor then checks both the word and the exact cycle at the falling edge that follows, so a divider off by one, an extra register stage or a wrong bit order each show up as a mismatch. The handshake, discard and disable cases are checked one falling edge after the acknowledge or `enable` change that should take effect.

// File: rtl/roent_collector.sv
module roent_collector #(
  parameter int NOSC    = 32,
  parameter int WORD_W  = 32,
  parameter int DIV_W   = 16,
  parameter bit EXT_OSC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NOSC-1:0]   op_a,
  input  logic [NOSC-1:0]   op_b,
  input  logic [NOSC-1:0]   osc_ext,
  input  logic [DIV_W-1:0]  div_limit,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  input  logic              word_ack
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [NOSC-1:0]   osc_raw;
  logic [NOSC-1:0]   sync1, sync2;
  logic [DIV_W-1:0]  pre_cnt;
  logic              strobe;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] next_word;
  logic              ent_bit;
  logic              word_done;

  // Adder-carry oscillators: inverted carry-out fed back as carry-in.
  for (genvar i = 0; i < NOSC; i++) begin : g_osc
    logic cin;
    logic carry;
    assign carry      = (op_a[i] & op_b[i]) | (cin & (op_a[i] ^ op_b[i]));
    assign osc_raw[i] = ~carry;
    if (EXT_OSC) begin : g_ext
      assign cin = osc_ext[i];
    end else begin : g_ring
      assign cin = enable & osc_raw[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= osc_raw;
      sync2 <= sync1;
    end
  end

  assign strobe = enable && (pre_cnt >= div_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_cnt <= '0;
    else if (!enable || strobe) pre_cnt <= '0;
    else                        pre_cnt <= pre_cnt + 1'b1;
  end

  assign ent_bit   = ^sync2;
  assign next_word = {shift_q[WORD_W-2:0], ent_bit};
  assign word_done = strobe && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else if (!enable) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else if (strobe) begin
      bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
      shift_q <= next_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_out   <= '0;
    end else if (!enable) begin
      word_valid <= 1'b0;
    end else if (word_valid) begin
      if (word_ack) word_valid <= 1'b0;
    end else if (word_done) begin
      word_valid <= 1'b1;
      word_out   <= next_word;
    end
  end

endmodule

// File: rtl/roent_collector_chk.sv
module roent_collector_chk #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              word_ack,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_out,
  input logic [DIV_W-1:0]  div_limit,
  input logic              strobe,
  input logic [CNT_W-1:0]  bit_cnt
);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && word_valid && !word_ack |=> word_valid && $stable(word_out));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ack |=> !word_valid);

  // R8
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !word_valid && bit_cnt == '0);

  // R5
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(strobe) && $past(bit_cnt) == CNT_W'(WORD_W - 1));

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && div_limit != '0 && $stable(div_limit) |=> !strobe);

  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid && !strobe |=> !word_valid);

endmodule

bind roent_collector roent_collector_chk #(
  .WORD_W(WORD_W),
  .DIV_W (DIV_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .word_ack  (word_ack),
  .word_valid(word_valid),
  .word_out  (word_out),
  .div_limit (div_limit),
  .strobe    (strobe),
  .bit_cnt   (bit_cnt)
);

// File: tb/roent_collector_tb.sv
module roent_collector_tb;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic [31:0] op_a, op_b, osc_ext;
  logic [15:0] div_limit;
  logic [31:0] word_out;
  logic        word_valid;
  logic        word_ack;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit auto_ack = 1'b0;

  typedef struct { logic [31:0] w; int due; } exp_t;
  exp_t        q[$];
  logic [31:0] words_seen[$];

  roent_collector u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .op_a(op_a), .op_b(op_b),
    .osc_ext(osc_ext), .div_limit(div_limit), .word_out(word_out),
    .word_valid(word_valid), .word_ack(word_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] pat(input int seed, input int idx);
    logic [31:0] x;
    x = (32'(seed) * 32'h9E3779B9) ^ (32'(idx) * 32'h85EBCA6B);
    x = x ^ (x >> 15) ^ (x << 7);
    return x;
  endfunction

  // Driver: starts on a falling edge with enable low; changes the oscillator
  // pattern right after each sample edge and predicts each word and its edge.
  task automatic stream(input int nwords, input int lim, input int seed, input bit push);
    logic [31:0] w;
    int idx;
    idx = 0;
    words_seen.delete();
    div_limit = 16'(lim);
    osc_ext   = pat(seed, 0);
    enable    = 1'b1;
    for (int n = 0; n < nwords; n++) begin
      w = '0;
      for (int k = 0; k < 32; k++) begin
        w = {w[30:0], ^osc_ext};
        if (k == 31) begin
          repeat (lim) @(posedge clk);
          @(negedge clk);
          words_seen.push_back(w);
          if (push) q.push_back('{w, cyc + 1});
          @(posedge clk);
        end else begin
          repeat (lim + 1) @(posedge clk);
        end
        @(negedge clk);
        idx++;
        osc_ext = pat(seed, idx);
      end
    end
  endtask

  // Monitor: pops the scoreboard when a word appears and acknowledges it.
  always @(negedge clk) begin
    exp_t e;
    if (auto_ack) begin
      if (word_ack) word_ack = 1'b0;
      else if (word_valid) begin
        if (q.size() == 0) chk("R7 unexpected word", word_out, 32'hx);
        else begin
          e = q.pop_front();
          chk("R3/R4 word content", word_out, e.w);
          chk("R5 due cycle (R2 divider)", 32'(cyc), 32'(e.due));
        end
        word_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; op_a = '1; op_b = '0; osc_ext = '0;
    div_limit = 16'd3; word_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(word_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(word_valid), 32'd0);
    chk("R1 word after reset", word_out, 32'd0);

    // R2 R3 R4 R5: back-to-back words at two divider settings
    auto_ack = 1'b1;
    stream(3, 2, 1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R5 all words delivered", 32'(q.size()), 32'd0);
    enable = 1'b0;
    @(negedge clk);
    stream(2, 5, 7, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 all words delivered", 32'(q.size()), 32'd0);
    enable = 1'b0;

    // R8: partial word abandoned, fresh word aligned after re-enable
    @(negedge clk);
    div_limit = 16'd2;
    enable = 1'b1;
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 valid while disabled", 32'(word_valid), 32'd0);
    stream(1, 3, 9, 1'b1);
    repeat (4) @(negedge clk);
    chk("R8 fresh word delivered", 32'(q.size()), 32'd0);
    enable = 1'b0;
    @(negedge clk);

    // R8: disable drops a pending word
    auto_ack = 1'b0;
    word_ack = 1'b0;
    stream(1, 2, 11, 1'b0);
    chk("R5 valid after 32 samples", 32'(word_valid), 32'd1);
    chk("R3 pending word", word_out, words_seen[0]);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 disable clears valid", 32'(word_valid), 32'd0);
    @(negedge clk);

    // R9 R7 R6: stray ack mid-word, second word discarded, hold then ack
    fork
      stream(2, 2, 13, 1'b0);
      begin
        repeat (40) @(negedge clk);
        word_ack = 1'b1;
        @(negedge clk);
        word_ack = 1'b0;
      end
    join
    chk("R6 valid held", 32'(word_valid), 32'd1);
    chk("R7/R9 first word kept", word_out, words_seen[0]);
    repeat (20) @(negedge clk);
    chk("R6 valid still held", 32'(word_valid), 32'd1);
    chk("R6 word stable", word_out, words_seen[0]);
    word_ack = 1'b1;
    @(negedge clk);
    word_ack = 1'b0;
    chk("R6 ack clears valid", 32'(word_valid), 32'd0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule